// File: doc/BRIEF.md
# Decision-Directed Symbol Timing Recovery

This block recovers the symbol clock of a two-level pulse-amplitude stream. The stream runs at 9600 bit/s and reaches the block already resampled to 19.2 kHz, so each symbol carries two samples. For every symbol the block takes three samples: the on-time sample and the two half-symbol neighbours around it. From these it forms a timing error. The error is the on-time value multiplied by the difference between the hard sign decisions on the later and earlier neighbours. A positive error means the block is sampling too late. A negative error means it is sampling too early.

The errors are summed in a random-walk accumulator. When the sum reaches a threshold set at run time, the block moves a fractional-delay index by one place, and the accumulator returns to zero. The index picks the coefficient set of an external polyphase interpolator. A positive crossing moves the sampling instant earlier and a negative crossing moves it later. The index has a fixed number of positions that together cover one input sample. When a step runs off either end, the index wraps round, and the decision grid gains or loses one input sample so that the timing stays continuous.

With each decision the block outputs a one-cycle decision strobe, the bit decided from the on-time sample, and the current interpolator phase index.

Top module: `sym_timing_rec`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dec_stb` is 0, `dec_bit` is 0 and `phase_idx` is PHASES/2 (4 by default). The accumulator and the sample history are zero.
- R2: A sample counts only when `in_valid` is 1 at a clock edge. With no wrap, `dec_stb` is high for exactly one cycle, in the cycle after every second counted sample, starting with the second sample after reset. The counted sample that triggers the strobe is the late sample. The counted sample before it is the on-time sample, and the one before that is the early sample.
- R3: In the cycle where `dec_stb` is high, `dec_bit` is 1 when the on-time sample is zero or positive and 0 when it is negative. `dec_bit` holds that value until the next strobe.
- R4: At each strobe the timing error is `ontime * (D(late) - D(early))`, where D gives +1 for a sample of zero or more and -1 otherwise. The error is added to a signed accumulator. After every index step the accumulator is cleared to zero.
- R5: If the updated sum is greater than or equal to `thr`, the index decreases by one, which moves sampling earlier.
- R6: If the R5 condition does not hold and the updated sum is less than or equal to `-thr`, the index increases by one, which moves sampling later.
- R7: `phase_idx` changes only in the cycle where `dec_stb` rises, and by at most one place, with wrap-around.
- R8: A decrease from index 0 wraps to PHASES-1. The next strobe then follows after one counted sample instead of two.
- R9: An increase from PHASES-1 wraps to 0. The next strobe then follows after three counted samples instead of two.
- R10: A clock edge with `in_valid` low changes nothing: there is no strobe, no shift of the history, no change to the accumulator and no change to the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new 19.2 kHz sample is present |
| in_sample | input | W | Signed two's-complement sample |
| thr | input | ACC_W-2 | Unsigned accumulator threshold that triggers a step |
| dec_stb | output | 1 | One-cycle decision strobe |
| dec_bit | output | 1 | Bit decided from the on-time sample |
| phase_idx | output | clog2(PHASES) | Coefficient-set index for the interpolator |

## Verification
The decision strobe and an index wrap can happen at the same clock edge. In that case the wrap reloads the sample counter at the same moment the counter would normally restart. The bench provokes this by setting the threshold to 1 over a long run of pseudo-random samples, which makes the index walk round in both directions many times. After every strobe it measures the number of counted samples up to the next strobe. It expects one sample after a downward wrap and three after an upward wrap. It also compares strobe, bit and index against a behavioural model on every clock.

// File: rtl/str_pkg.sv
package str_pkg;
   // Grid correction requested by the phase stepper when the index wraps
   typedef enum logic [1:0] {
      SLIP_NONE  = 2'd0,
      SLIP_SKIP  = 2'd1,   // next strobe after one sample
      SLIP_EXTRA = 2'd2    // next strobe after three samples
   } slip_e;

   // Sample-counter reload values; a strobe fires when the counter reads 1
   localparam logic [1:0] CNT_NORMAL = 2'd0;
   localparam logic [1:0] CNT_SHORT  = 2'd1;
   localparam logic [1:0] CNT_LONG   = 2'd3;
endpackage

// File: rtl/str_window.sv
module str_window
   import str_pkg::*;
#(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_sample,
   input  slip_e               slip,
   output logic                fire,
   output logic signed [W-1:0] early,
   output logic signed [W-1:0] ontime,
   output logic signed [W-1:0] late
);
   logic [1:0]          cnt_q;
   logic signed [W-1:0] h1_q, h2_q;

   assign fire   = in_valid && (cnt_q == 2'd1);
   assign early  = h2_q;
   assign ontime = h1_q;
   assign late   = in_sample;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_NORMAL;
         h1_q  <= '0;
         h2_q  <= '0;
      end else if (in_valid) begin
         h2_q <= h1_q;
         h1_q <= in_sample;
         if (fire) begin
            case (slip)
               SLIP_SKIP:  cnt_q <= CNT_SHORT;
               SLIP_EXTRA: cnt_q <= CNT_LONG;
               default:    cnt_q <= CNT_NORMAL;
            endcase
         end else begin
            cnt_q <= cnt_q + 2'd1;
         end
      end
   end

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(h1_q) && $stable(cnt_q)); // R10
endmodule

// File: rtl/str_err_acc.sv
module str_err_acc #(
   parameter int W     = 12,
   parameter int ACC_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic signed [W-1:0] early,
   input  logic signed [W-1:0] ontime,
   input  logic signed [W-1:0] late,
   input  logic [ACC_W-3:0]    thr,
   output logic                step_dn,
   output logic                step_up
);
   if (ACC_W < W + 2) begin : g_bad_acc
      $error("str_err_acc: ACC_W must be at least W+2");
   end

   logic signed [ACC_W-1:0] acc_q, acc_nx, ted, on_x, thr_s;

   assign on_x  = ACC_W'(ontime);
   assign thr_s = signed'({2'b00, thr});

   // sign(late) - sign(early) is 0 or +/-2
   always_comb begin
      if (early[W-1] == late[W-1])
         ted = '0;
      else if (!late[W-1])
         ted = on_x <<< 1;
      else
         ted = -(on_x <<< 1);
   end

   assign acc_nx  = acc_q + ted;
   assign step_dn = fire && (acc_nx >= thr_s);
   assign step_up = fire && !step_dn && (acc_nx <= -thr_s);

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (fire)
         acc_q <= (step_dn || step_up) ? '0 : acc_nx;
   end

   AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn || step_up) |=> (acc_q == '0)); // R4
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(acc_q)); // R10
endmodule

// File: rtl/str_phase.sv
module str_phase
   import str_pkg::*;
#(
   parameter int PHASES = 8,
   localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_dn,
   input  logic            step_up,
   output logic [PH_W-1:0] phase_q,
   output slip_e           slip
);
   localparam logic [PH_W-1:0] LAST   = PH_W'(PHASES - 1);
   localparam logic [PH_W-1:0] CENTRE = PH_W'(PHASES / 2);

   if (PHASES < 2) begin : g_bad_ph
      $error("str_phase: PHASES must be at least 2");
   end

   logic [PH_W-1:0] ph_dec, ph_inc;

   if ((PHASES & (PHASES - 1)) == 0) begin : g_pow2
      assign ph_dec = phase_q - 1'b1;
      assign ph_inc = phase_q + 1'b1;
   end else begin : g_cmp
      assign ph_dec = (phase_q == '0)  ? LAST : phase_q - 1'b1;
      assign ph_inc = (phase_q == LAST) ? '0  : phase_q + 1'b1;
   end

   always_comb begin
      if (step_dn && phase_q == '0)
         slip = SLIP_SKIP;
      else if (step_up && phase_q == LAST)
         slip = SLIP_EXTRA;
      else
         slip = SLIP_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase_q <= CENTRE;
      else if (step_dn)
         phase_q <= ph_dec;
      else if (step_up)
         phase_q <= ph_inc;
   end

   AST_SKIP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (slip == SLIP_SKIP) |=> (phase_q == LAST)); // R8
   AST_EXTRA_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (slip == SLIP_EXTRA) |=> (phase_q == '0)); // R9
endmodule

// File: rtl/sym_timing_rec.sv
module sym_timing_rec
   import str_pkg::*;
#(
   parameter int W      = 12,
   parameter int PHASES = 8,
   parameter int ACC_W  = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               in_valid,
   input  logic signed [W-1:0]                in_sample,
   input  logic [ACC_W-3:0]                   thr,
   output logic                               dec_stb,
   output logic                               dec_bit,
   output logic [$clog2(PHASES)-1:0]          phase_idx
);
   logic                fire, step_dn, step_up;
   logic signed [W-1:0] s_early, s_on, s_late;
   slip_e               slip;

   str_window #(.W(W)) u_win (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .slip(slip), .fire(fire), .early(s_early), .ontime(s_on), .late(s_late)
   );

   str_err_acc #(.W(W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .fire(fire), .early(s_early), .ontime(s_on),
      .late(s_late), .thr(thr), .step_dn(step_dn), .step_up(step_up)
   );

   str_phase #(.PHASES(PHASES)) u_ph (
      .clk(clk), .rst_n(rst_n), .step_dn(step_dn), .step_up(step_up),
      .phase_q(phase_idx), .slip(slip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_stb <= 1'b0;
         dec_bit <= 1'b0;
      end else begin
         dec_stb <= fire;
         if (fire)
            dec_bit <= ~s_on[W-1];
      end
   end

   AST_STB_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dec_stb |-> $past(in_valid)); // R2
   AST_PH_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_idx != $past(phase_idx)) |-> dec_stb); // R7
   AST_BIT_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_stb |-> $stable(dec_bit)); // R3
endmodule

// File: tb/test_sym_timing_rec.sv
module test_sym_timing_rec;
   localparam int CLK_PERIOD = 10;
   localparam int W = 12, PHASES = 8, ACC_W = 16;
   localparam int LAST = PHASES - 1;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic signed [W-1:0] in_sample = '0;
   logic [ACC_W-3:0] thr = '0;
   logic dec_stb, dec_bit;
   logic [2:0] phase_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   sym_timing_rec #(.W(W), .PHASES(PHASES), .ACC_W(ACC_W)) i_sym_timing_rec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .thr(thr), .dec_stb(dec_stb), .dec_bit(dec_bit), .phase_idx(phase_idx)
   );

   int n_cmp = 0, n_bad = 0;
   // behavioural reference
   int m_h1, m_h2, m_need, m_acc, m_ph, m_vcnt;
   bit m_stb, m_bit, m_idle;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_h1 = 0; m_h2 = 0; m_need = 2; m_acc = 0; m_ph = PHASES/2;
         m_vcnt = 0; m_stb = 0; m_bit = 0; m_idle = 0;
      end else if (in_valid) begin
         int s, de, dl, a;
         s = int'(in_sample);
         m_idle = 0; m_vcnt++; m_need--;
         m_stb = (m_need == 0);
         if (m_stb) begin
            de = (m_h2 >= 0) ? 1 : -1;
            dl = (s >= 0) ? 1 : -1;
            a = m_acc + m_h1 * (dl - de);
            m_bit = (m_h1 >= 0);
            m_need = 2;
            if (a >= int'(thr)) begin
               a = 0;
               if (m_ph == 0) begin m_ph = LAST; m_need = 1; end else m_ph--;
            end else if (a <= -int'(thr)) begin
               a = 0;
               if (m_ph == LAST) begin m_ph = 0; m_need = 3; end else m_ph++;
            end
            m_acc = a;
         end
         m_h2 = m_h1; m_h1 = s;
      end else begin
         m_stb = 0; m_idle = 1;
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison and strobe-gap monitor
   bit mon_on = 0;
   int last_v = 0, exp_gap = 2, ph_prev = PHASES/2, wraps_dn = 0, wraps_up = 0;
   always @(negedge clk) if (mon_on) begin
      check(dec_stb == m_stb, m_idle ? "R10 strobe" : "R2 strobe", dec_stb, m_stb);
      check(dec_bit == m_bit, "R3 bit", dec_bit, m_bit);
      check(int'(phase_idx) == m_ph, "R4/R5/R6/R7 phase", phase_idx, m_ph);
      if (dec_stb) begin
         check((m_vcnt - last_v) == exp_gap,
               exp_gap == 1 ? "R8 gap" : (exp_gap == 3 ? "R9 gap" : "R2 gap"),
               m_vcnt - last_v, exp_gap);
         last_v = m_vcnt;
         if (ph_prev == 0 && phase_idx == LAST) begin exp_gap = 1; wraps_dn++; end
         else if (ph_prev == LAST && phase_idx == 0) begin exp_gap = 3; wraps_up++; end
         else exp_gap = 2;
      end
      ph_prev = phase_idx;
   end

   int unsigned rng = 32'h1234_5678;
   function automatic logic signed [W-1:0] next_sample();
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      if (rng[7:4] == 4'd0) return '0;
      if (rng[7:4] == 4'd1) return {1'b1, {(W-1){1'b0}}};
      return rng[W+7:8];
   endfunction

   task automatic run(int cycles, int valid_pct, int unsigned t);
      thr = t[ACC_W-3:0];
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         in_valid  = ((rng % 100) < valid_pct);
         in_sample = next_sample();
         if ((i % 97) > 80) in_valid = 1'b0;   // idle stretches
      end
   endtask

   bit done = 0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL R2 watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      in_valid = 1'b1; in_sample = 12'sh7FF;   // ignored during reset
      @(negedge clk);
      check(dec_stb == 0 && dec_bit == 0, "R1 reset outputs", {dec_stb, dec_bit}, 0);
      check(phase_idx == PHASES/2, "R1 reset phase", phase_idx, PHASES/2);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_stb == 0 && phase_idx == PHASES/2, "R1 after release",
            phase_idx, PHASES/2);
      mon_on = 1;
      run(800, 100, 16383);
      run(3000, 70, 1);
      run(1500, 90, 2000);
      run(400, 100, 0);
      @(negedge clk); in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(wraps_dn > 0, "R8 downward wrap seen", wraps_dn, 1);
      check(wraps_up > 0, "R9 upward wrap seen", wraps_up, 1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule